// File: doc/BRIEF.md
# Partitioned Saturating SIMD Adder

This block is a 64-bit add/subtract datapath that works either as one full-width adder or as a set of independent narrow lanes of 8, 16 or 32 bits. Every lane is computed in the same cycle. The carry chain is broken at each lane edge, so no lane's carry or borrow reaches its neighbour. Signed lanes are two's-complement fixed-point values with the binary point just below the sign bit. Unsigned lanes are plain integers.

Each lane reports overflow. When clamping is enabled, an overflowing lane returns the extreme value that lies nearest to its true result. When clamping is off, the lane keeps its modulo result and still raises its flag. A parameter selects whether the outputs are registered or driven directly from the combinational logic.

Top module: `psat_simd_adder`

## Requirements
- R1: `lane_sel_i` sets the lane width: 2'b00 gives eight 8-bit lanes, 2'b01 four 16-bit lanes, 2'b10 two 32-bit lanes and 2'b11 one 64-bit lane. Lane k covers bits [k*w+w-1 : k*w]. No carry or borrow crosses a lane boundary.
- R2: With `sub_i`=0 and no overflow, each lane's result is a+b modulo 2^w.
- R3: With `sub_i`=1 and no overflow, each lane's result is a-b modulo 2^w.
- R4: An unsigned lane (`signed_i`=0) overflows when its sum needs more than w bits (add), or when b>a (subtract).
- R5: A signed lane (`signed_i`=1) overflows when its exact result lies outside -2^(w-1) .. 2^(w-1)-1.
- R6: `ovf_o` has one bit per byte. Bit j equals the overflow of the lane that contains byte j, so every byte of a lane reports the same flag.
- R7: With `sat_i`=1, an overflowing unsigned lane returns all ones on an add and zero on a subtract.
- R8: With `sat_i`=1, an overflowing signed lane returns 0x7F..F when the exact result is positive and 0x80..0 when it is negative.
- R9: With `sat_i`=0, an overflowing lane returns its wrapped modulo result and still raises its flags.
- R10: With `REG_OUT`=1 (the default), `sum_o` and `ovf_o` appear one clock after the inputs. A rising edge with `rst_n`=0 clears both outputs to zero.
- R11: In 64-bit mode, a carry ripples through all eight bytes as one adder.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset |
| a_i | input | 64 | Operand A |
| b_i | input | 64 | Operand B |
| lane_sel_i | input | 2 | Lane width select (R1 encoding) |
| sub_i | input | 1 | 1 = A minus B, 0 = A plus B |
| signed_i | input | 1 | 1 = signed fixed-point lanes |
| sat_i | input | 1 | 1 = clamp overflowing lanes |
| sum_o | output | 64 | Lane results |
| ovf_o | output | 8 | Per-byte overflow flags |

## Verification
The block holds no state apart from the optional output register. A wrong lane start or a misrouted top-byte index therefore shows up at the ports on the very next registered result. It appears either as a carry leaking into the next lane or as flags that differ between bytes of one lane. A wrong overflow rule is different: it stays hidden until an operand pair actually overflows, and then shows as a wrong clamp value or a missing flag. For that reason the stimulus mixes random operands with directed edge values (all ones, sign-bit boundaries, zero minus one) in every lane width and in both signed and unsigned modes.

// File: rtl/psat_pkg.sv
// Shared definitions for the partitioned saturating adder.
// Assumes the data word is a whole number of bytes.
package psat_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        LANE_B8  = 2'b00,
        LANE_B16 = 2'b01,
        LANE_B32 = 2'b10,
        LANE_B64 = 2'b11
    } lane_sz_e;

    // Number of bytes per lane for a given width select.
    function automatic int lane_bytes(input logic [1:0] sel);
        return 1 << sel;
    endfunction
endpackage

// File: rtl/psat_carry_chain.sv
// Byte-sliced ripple adder with a breakable carry at each byte.
// Each slice takes the lane carry-in (sub_i) when it starts a lane,
// otherwise the carry out of the slice below. Operand B is inverted
// for subtraction. Assumes BW >= 2.
module psat_carry_chain #(
    parameter int NBYTES = 8,
    parameter int BW     = 8,
    localparam int DW    = NBYTES * BW
) (
    input  logic [DW-1:0]     a_i,
    input  logic [DW-1:0]     b_i,
    input  logic              sub_i,
    input  logic [NBYTES-1:0] lane_start_i,
    output logic [DW-1:0]     sum_o,
    output logic [NBYTES-1:0] cout_o,
    output logic [NBYTES-1:0] cmsb_o
);
    logic [NBYTES-1:0] cin;

    for (genvar i = 0; i < NBYTES; i++) begin : g_slice
        logic [BW-1:0] as, bx, low;

        // Pick the carry-in: lane start or ripple from below.
        if (i == 0) begin : g_first
            assign cin[i] = sub_i;
        end else begin : g_rest
            assign cin[i] = lane_start_i[i] ? sub_i : cout_o[i-1];
        end

        assign as  = a_i[i*BW +: BW];
        assign bx  = b_i[i*BW +: BW] ^ {BW{sub_i}};
        // Low bits sum; its top bit is the carry into the slice MSB.
        assign low = {1'b0, as[BW-2:0]} + {1'b0, bx[BW-2:0]} + {{(BW-1){1'b0}}, cin[i]};
        assign cmsb_o[i] = low[BW-1];
        assign sum_o[i*BW +: BW] = {as[BW-1] ^ bx[BW-1] ^ low[BW-1], low[BW-2:0]};
        assign cout_o[i] = (as[BW-1] & bx[BW-1]) | (low[BW-1] & (as[BW-1] ^ bx[BW-1]));
    end
endmodule

// File: rtl/psat_clamp.sv
// Per-byte output select: wrapped sum or the saturation limit.
// Assumes ovf_i and neg_i come from the top byte of this byte's lane.
module psat_clamp #(
    parameter int BW = 8
) (
    input  logic [BW-1:0] wrap_i,
    input  logic          is_top_i,
    input  logic          ovf_i,
    input  logic          neg_i,
    input  logic          signed_i,
    input  logic          sub_i,
    input  logic          sat_i,
    output logic [BW-1:0] out_o
);
    // Choose the limit byte, or pass the wrapped byte through.
    always_comb begin
        out_o = wrap_i;
        if (sat_i && ovf_i) begin
            if (signed_i) begin
                out_o = is_top_i ? {neg_i, {(BW-1){~neg_i}}} : {BW{~neg_i}};
            end else begin
                out_o = sub_i ? {BW{1'b0}} : {BW{1'b1}};
            end
        end
    end
endmodule

// File: rtl/psat_simd_adder.sv
// Partitioned 64-bit add/subtract with per-lane overflow and optional
// saturation. Lanes of 8/16/32/64 bits. REG_OUT adds one output
// register with synchronous active-low reset. Assumes inputs are
// stable around the clock edge when REG_OUT is set.
module psat_simd_adder
    import psat_pkg::*;
#(
    parameter int NBYTES  = 8,
    parameter bit REG_OUT = 1'b1,
    localparam int BW     = BYTE_W,
    localparam int DW     = NBYTES * BW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:0]     a_i,
    input  logic [DW-1:0]     b_i,
    input  logic [1:0]        lane_sel_i,
    input  logic              sub_i,
    input  logic              signed_i,
    input  logic              sat_i,
    output logic [DW-1:0]     sum_o,
    output logic [NBYTES-1:0] ovf_o
);
    logic [NBYTES-1:0] lane_start, lane_top, cout, cmsb, ovf_at, ovf_c, neg_c;
    logic [DW-1:0]     wrap_sum, res_c;

    // Mark lane starts and tops, and route each lane's top-byte info to all its bytes.
    always_comb begin
        int nb;
        int ti;
        nb = lane_bytes(lane_sel_i);
        for (int i = 0; i < NBYTES; i++) begin
            lane_start[i] = ((i & (nb - 1)) == 0);
            lane_top[i]   = ((i & (nb - 1)) == nb - 1);
            ti            = i | (nb - 1);
            if (ti > NBYTES - 1) ti = NBYTES - 1;
            ovf_c[i]      = ovf_at[ti];
            neg_c[i]      = a_i[ti*BW + BW - 1];
        end
    end

    psat_carry_chain #(.NBYTES(NBYTES), .BW(BW)) u_chain (
        .a_i          (a_i),
        .b_i          (b_i),
        .sub_i        (sub_i),
        .lane_start_i (lane_start),
        .sum_o        (wrap_sum),
        .cout_o       (cout),
        .cmsb_o       (cmsb)
    );

    // Overflow rule per byte, meaningful at lane tops only.
    always_comb begin
        for (int j = 0; j < NBYTES; j++) begin
            ovf_at[j] = signed_i ? (cmsb[j] ^ cout[j]) : (cout[j] ^ sub_i);
        end
    end

    for (genvar i = 0; i < NBYTES; i++) begin : g_clamp
        psat_clamp #(.BW(BW)) u_clamp (
            .wrap_i   (wrap_sum[i*BW +: BW]),
            .is_top_i (lane_top[i]),
            .ovf_i    (ovf_c[i]),
            .neg_i    (neg_c[i]),
            .signed_i (signed_i),
            .sub_i    (sub_i),
            .sat_i    (sat_i),
            .out_o    (res_c[i*BW +: BW])
        );
    end

    if (REG_OUT) begin : g_reg
        // Capture the lane results, clearing on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sum_o <= '0;
                ovf_o <= '0;
            end else begin
                sum_o <= res_c;
                ovf_o <= ovf_c;
            end
        end

        // R10
        reg_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> (sum_o == $past(res_c) && ovf_o == $past(ovf_c)));
    end else begin : g_comb
        assign sum_o = res_c;
        assign ovf_o = ovf_c;
    end

    // R6
    wide_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_sel_i == LANE_B64) |-> (ovf_c == '0 || ovf_c == '1));

    // R7
    usat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_i && !signed_i && !sub_i && ovf_c[0]) |-> (res_c[BW-1:0] == {BW{1'b1}}));

    // R7
    usat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_i && !signed_i && sub_i && ovf_c[0]) |-> (res_c[BW-1:0] == '0));

    // R8
    ssat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_i && signed_i && ovf_c[NBYTES-1]) |->
        (res_c[DW-1 -: BW] == {1'b0, {(BW-1){1'b1}}} || res_c[DW-1 -: BW] == {1'b1, {(BW-1){1'b0}}}));

    // R9
    wrap_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sat_i |-> (res_c == wrap_sum));
endmodule

// File: tb/tb_psat_simd_adder.sv
module tb_psat_simd_adder;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] a, b;
    logic [1:0]  sel;
    logic        sub, sgn, sat;
    logic [63:0] sum;
    logic [7:0]  ovf;
    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    psat_simd_adder dut (
        .clk(clk), .rst_n(rst_n), .a_i(a), .b_i(b), .lane_sel_i(sel),
        .sub_i(sub), .signed_i(sgn), .sat_i(sat), .sum_o(sum), .ovf_o(ovf)
    );

    // Expected lane results from the requirements.
    function automatic void model(input logic [63:0] ia, ib, input logic [1:0] s,
                                  input logic isub, isgn, isat,
                                  output logic [63:0] r, output logic [7:0] f);
        int w  = 8 << s;
        int nl = 64 / w;
        r = '0; f = '0;
        for (int l = 0; l < nl; l++) begin
            logic [65:0] mask, ua, ub, ur, lane;
            logic signed [65:0] sa, sb, sr, maxv, minv;
            logic ov;
            mask = (66'd1 << w) - 66'd1;
            ua = ({2'b0, ia} >> (l*w)) & mask;
            ub = ({2'b0, ib} >> (l*w)) & mask;
            if (!isgn) begin
                ur = isub ? ua - ub : ua + ub;
                ov = isub ? (ua < ub) : ur[w];
                lane = (isat && ov) ? (isub ? 66'd0 : mask) : (ur & mask);
            end else begin
                sa = ua[w-1] ? $signed(ua | ~mask) : $signed(ua);
                sb = ub[w-1] ? $signed(ub | ~mask) : $signed(ub);
                sr = isub ? sa - sb : sa + sb;
                maxv = (66'sd1 <<< (w-1)) - 66'sd1;
                minv = -(66'sd1 <<< (w-1));
                ov = (sr > maxv) || (sr < minv);
                if (isat && ov) lane = (sr < 0) ? ($unsigned(minv) & mask) : $unsigned(maxv);
                else            lane = $unsigned(sr) & mask;
            end
            r = r | (lane[63:0] << (l*w));
            if (ov) for (int k = 0; k < w/8; k++) f[l*(w/8)+k] = 1'b1;
        end
    endfunction

    task automatic check(input logic [63:0] er, input logic [7:0] ef, input string tag);
        n_tests++;
        if (sum !== er || ovf !== ef) begin
            n_fail++;
            $display("FAIL %s: sum=%h ovf=%h expected sum=%h ovf=%h", tag, sum, ovf, er, ef);
        end
    endtask

    // Drive at a falling edge, sample one falling edge later (after the register).
    task automatic run(input logic [63:0] ia, ib, input logic [1:0] s,
                       input logic isub, isgn, isat, input string tag);
        logic [63:0] er; logic [7:0] ef;
        a = ia; b = ib; sel = s; sub = isub; sgn = isgn; sat = isat;
        model(ia, ib, s, isub, isgn, isat, er, ef);
        @(negedge clk);
        check(er, ef, tag);
    endtask

    // Directed value check against hand-computed results.
    task automatic run_exp(input logic [63:0] ia, ib, input logic [1:0] s,
                           input logic isub, isgn, isat,
                           input logic [63:0] er, input logic [7:0] ef, input string tag);
        a = ia; b = ib; sel = s; sub = isub; sgn = isgn; sat = isat;
        @(negedge clk);
        check(er, ef, tag);
    endtask

    initial begin
        int seed;
        rst_n = 1'b0; a = '0; b = '0; sel = 2'b00; sub = 0; sgn = 0; sat = 0;
        repeat (3) @(negedge clk);
        check(64'h0, 8'h0, "R10 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R9/R4 unsigned byte wrap with flags
        run_exp({8{8'hFF}}, {8{8'h01}}, 2'b00, 0, 0, 0, 64'h0, 8'hFF, "R9");
        // R7 unsigned clamp high
        run_exp({8{8'hFF}}, {8{8'h01}}, 2'b00, 0, 0, 1, {8{8'hFF}}, 8'hFF, "R7");
        // R1 no carry across 16-bit lanes
        run_exp({4{16'h00FF}}, {4{16'h0001}}, 2'b01, 0, 0, 1, {4{16'h0100}}, 8'h00, "R1");
        // R1 carry out of 16-bit lane does not leak
        run_exp({4{16'hFFFF}}, {4{16'h0001}}, 2'b01, 0, 0, 0, 64'h0, 8'hFF, "R1");
        // R7/R3 unsigned 32-bit underflow clamps to zero
        run_exp(64'h0, {2{32'h1}}, 2'b10, 1, 0, 1, 64'h0, 8'hFF, "R7");
        // R3 wrapped borrow per byte
        run_exp(64'h0, {8{8'h01}}, 2'b00, 1, 0, 0, {8{8'hFF}}, 8'hFF, "R3");
        // R8 signed positive clamp
        run_exp({8{8'h7F}}, {8{8'h01}}, 2'b00, 0, 1, 1, {8{8'h7F}}, 8'hFF, "R8");
        // R9/R5 signed wrap keeps flag
        run_exp({8{8'h7F}}, {8{8'h01}}, 2'b00, 0, 1, 0, {8{8'h80}}, 8'hFF, "R5");
        // R8 signed negative clamp on subtract
        run_exp({4{16'h8000}}, {4{16'h0001}}, 2'b01, 1, 1, 1, {4{16'h8000}}, 8'hFF, "R8");
        // R11 carry through the whole word
        run_exp(64'h0000_0000_FFFF_FFFF, 64'h1, 2'b11, 0, 0, 0, 64'h0000_0001_0000_0000, 8'h00, "R11");
        // R11 64-bit signed overflow clamps
        run_exp(64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 2'b11, 0, 1, 1, 64'h7FFF_FFFF_FFFF_FFFF, 8'hFF, "R11");
        // R6 only the overflowing 32-bit lane flags its bytes
        run_exp({32'h0000_0001, 32'h7FFF_FFFF}, {32'h1, 32'h1}, 2'b10, 0, 1, 1,
                {32'h0000_0002, 32'h7FFF_FFFF}, 8'h0F, "R6");
        // R5 signed no-overflow mixed signs
        run_exp({8{8'h80}}, {8{8'h7F}}, 2'b00, 0, 1, 1, {8{8'hFF}}, 8'h00, "R5");

        // Constrained random, fixed seed.
        seed = $urandom(32'h5EED_1234);
        for (int n = 0; n < 1200; n++) begin
            logic [63:0] ra, rb;
            logic [1:0] rs;
            logic rsub, rsgn, rsat;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            case ($urandom % 4)
                0: ra = ra | 64'h8080_8080_8080_8080;
                1: rb = ~ra;
                default: ;
            endcase
            rs = 2'($urandom); rsub = 1'($urandom); rsgn = 1'($urandom); rsat = 1'($urandom);
            run(ra, rb, rs, rsub, rsgn, rsat, rsgn ? "R5" : (rsub ? "R3" : "R2"));
        end

        // R10 reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check(64'h0, 8'h0, "R10 reset");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule